// File: doc/BRIEF.md
# Serial Three-Wire Memory Slave

This block is the slave side of a three-wire serial memory: chip select, serial clock and serial data in, with serial data out. A small register array stands in for the nonvolatile cells. Each command begins with a start bit of 1. A 2-bit opcode and an address follow, then data for the commands that write. The block performs word read, word write, word erase, fill and clear of the whole array, and arming and disarming of writes. A strap input picks 8-bit or 16-bit words, and the address field grows by one bit in 8-bit mode.

Program operations are self-timed. The cycle starts when chip select falls after a fully shifted write or erase. A counter sets its length. While the cycle runs, the block ignores new commands. A host that raises chip select during the cycle sees a busy level on the data output, and that level switches to ready once the cycle ends.

All three bus inputs are oversampled in the system clock domain through synchronizers. The serial clock therefore has to run well below the system clock. The array capacity is a parameter: 1, 4, 8 or 16 Kbit.

Top module: `mw_eeprom`

## Requirements
- R1: Bits are taken on rising serial-clock edges only while chip select is high. With chip select low, clock and data activity changes nothing, and the output is not driven (`dout_en` = 0).
- R2: A command opens with the first 1 seen while selected, so leading 0 bits are skipped. Next come 2 opcode bits, then an address of A bits, all sent MSB first. A = log2(Kbit·64) in 16-bit mode and A+1 in 8-bit mode.
- R3: Opcode 10 reads. After the last address bit the output drives a dummy 0. Each following rising edge presents the next word bit, MSB first. The edge after the LSB releases the output.
- R4: Opcode 01 takes a data word after the address and stores it at that address.
- R5: Opcode 11 sets every bit of the addressed word to 1.
- R6: Opcode 00 uses the top two address bits as a sub-code. A sub-code of 11 arms writes and 00 disarms them. Writes are disarmed after reset, and every program command is dropped while they are disarmed.
- R7: A program operation starts only on the falling edge of chip select, and only after its command was completely shifted in. If chip select falls earlier, the command is abandoned.
- R8: A program cycle lasts `PROG_CYCLES` clocks. Start bits received during the cycle are ignored.
- R9: If chip select rises while a cycle runs, the output drives 0 until the cycle ends and 1 after it. Chip select falling releases the output, and so does a start bit once the cycle has ended.
- R10: `org_sel` = 1 (the pad's pull-up level) selects 16-bit words and 0 selects 8-bit words. In 16-bit mode, word w occupies bytes 2w (high half) and 2w+1 (low half) of the 8-bit address space.
- R11: Sub-code 01 (followed by a data word) writes that word to every location. Sub-code 10 sets every bit of the array to 1.
- R12: After reset the array holds all ones, writes are disarmed and the output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| org_sel | input | 1 | Word width strap: 1 = 16-bit, 0 = 8-bit |
| dout | output | 1 | Serial data out |
| dout_en | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The assertions rely on a few properties of the inputs. `cs`, `sk` and `di` must each hold steady for several system clocks, so every synchronized edge is seen exactly once. `di` must already be settled when `sk` rises. `org_sel` must stay fixed for the whole of a command. The bench meets these conditions by holding each bus level for eight clocks and by changing the strap only while deselected. It also starts no status poll or command close enough to the end of a program cycle for the outcome to depend on which clock the cycle ends in.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_ARMED, ST_DONE
  } mw_state_e;

  typedef enum logic [1:0] {
    PG_WRITE, PG_ERASE, PG_WRALL, PG_ERALL
  } prog_kind_e;

  // address bits of a 16-bit-word array of the given capacity
  function automatic int word16_addr_bits(input int kbit);
    return $clog2(kbit * 64);
  endfunction
endpackage

// File: rtl/mw_edge_sync.sv
module mw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_lvl,
  output logic cs_rise,
  output logic cs_fall,
  output logic sk_rise,
  output logic di_lvl
);
  logic [STAGES-1:0] cs_q, sk_q, di_q;
  logic cs_d, sk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0;
      sk_q <= '0;
      di_q <= '0;
      cs_d <= 1'b0;
      sk_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[STAGES-2:0], cs_i};
      sk_q <= {sk_q[STAGES-2:0], sk_i};
      di_q <= {di_q[STAGES-2:0], di_i};
      cs_d <= cs_q[STAGES-1];
      sk_d <= sk_q[STAGES-1];
    end
  end

  assign cs_lvl  = cs_q[STAGES-1];
  assign cs_rise = cs_lvl & ~cs_d;
  assign cs_fall = ~cs_lvl & cs_d;
  assign sk_rise = sk_q[STAGES-1] & ~sk_d & cs_lvl;
  assign di_lvl  = di_q[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 625000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (start && cnt == '0) cnt <= CW'(CYCLES);
    else if (cnt != '0)          cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CYCLES));
endmodule

// File: rtl/mw_store.sv
module mw_store
  import mw_pkg::*;
#(
  parameter int AW16 = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            org16,
  input  logic            we,
  input  prog_kind_e      kind,
  input  logic [AW16:0]   addr,
  input  logic [15:0]     wdata,
  output logic [15:0]     rdata
);
  localparam int NB = 2 ** (AW16 + 1);

  logic [7:0]  mem [NB];
  logic [AW16:0] hi_i, lo_i;

  assign hi_i  = {addr[AW16-1:0], 1'b0};
  assign lo_i  = {addr[AW16-1:0], 1'b1};
  assign rdata = org16 ? {mem[hi_i], mem[lo_i]} : {8'h00, mem[addr]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      case (kind)
        PG_ERALL: for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
        PG_WRALL: for (int i = 0; i < NB; i++)
                    mem[i] <= (org16 && (i % 2 == 0)) ? wdata[15:8] : wdata[7:0];
        PG_ERASE: if (org16) begin
                    mem[hi_i] <= 8'hFF;
                    mem[lo_i] <= 8'hFF;
                  end else mem[addr] <= 8'hFF;
        default:  if (org16) begin
                    mem[hi_i] <= wdata[15:8];
                    mem[lo_i] <= wdata[7:0];
                  end else mem[addr] <= wdata[7:0];
      endcase
    end
  end
endmodule

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_pkg::*;
#(
  parameter int AW16 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          org16,
  input  logic          cs_rise,
  input  logic          cs_fall,
  input  logic          sk_rise,
  input  logic          di,
  input  logic          busy,
  input  logic [15:0]   rdata,
  output logic [AW16:0] addr_q,
  output logic [15:0]   data_q,
  output logic          prog_start,
  output prog_kind_e    prog_kind,
  output logic          wen,
  output logic          dout,
  output logic          dout_en
);
  mw_state_e     state;
  logic [4:0]    cnt, aw, dw;
  logic [1:0]    opc, sub;
  logic [15:0]   rd_word, rd_shift, rdata_shift;
  logic [AW16:0] addr_nx, sub_shift;
  logic          rd_en, rd_bit, status_mode;

  assign aw          = org16 ? 5'(AW16) : 5'(AW16 + 1);
  assign dw          = org16 ? 5'd16 : 5'd8;
  assign addr_nx     = {addr_q[AW16-1:0], di};
  assign sub_shift   = addr_nx >> (aw - 5'd2);
  assign sub         = sub_shift[1:0];
  assign rd_shift    = rd_word >> (dw - 5'd1 - cnt);
  assign rdata_shift = rdata >> (dw - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; opc <= '0; addr_q <= '0; data_q <= '0;
      rd_word <= '0; rd_en <= 1'b0; rd_bit <= 1'b0; status_mode <= 1'b0;
      wen <= 1'b0; prog_start <= 1'b0; prog_kind <= PG_WRITE;
    end else begin
      prog_start <= 1'b0;
      if (cs_fall) begin
        prog_start  <= (state == ST_ARMED) && wen;
        state       <= ST_IDLE;
        rd_en       <= 1'b0;
        status_mode <= 1'b0;
      end else if (cs_rise) begin
        status_mode <= busy;
      end else if (sk_rise) begin
        case (state)
          ST_IDLE: if (di && !busy) begin
            state <= ST_OPC; cnt <= '0; status_mode <= 1'b0;
          end
          ST_OPC: begin
            opc <= {opc[0], di};
            if (cnt == 5'd1) begin cnt <= '0; state <= ST_ADDR; end
            else cnt <= cnt + 1'b1;
          end
          ST_ADDR: begin
            addr_q <= addr_nx;
            if (cnt == aw - 5'd1) begin
              cnt <= '0;
              case (opc)
                2'b10: begin state <= ST_READ; rd_en <= 1'b1; rd_bit <= 1'b0; end
                2'b01: begin prog_kind <= PG_WRITE; state <= ST_DATA; end
                2'b11: begin prog_kind <= PG_ERASE; state <= ST_ARMED; end
                default: case (sub)
                  2'b11:   begin wen <= 1'b1; state <= ST_DONE; end
                  2'b00:   begin wen <= 1'b0; state <= ST_DONE; end
                  2'b10:   begin prog_kind <= PG_ERALL; state <= ST_ARMED; end
                  default: begin prog_kind <= PG_WRALL; state <= ST_DATA; end
                endcase
              endcase
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            data_q <= {data_q[14:0], di};
            if (cnt == dw - 5'd1) begin cnt <= '0; state <= ST_ARMED; end
            else cnt <= cnt + 1'b1;
          end
          ST_READ: begin
            if (cnt == '0) begin
              rd_word <= rdata; rd_bit <= rdata_shift[0]; cnt <= 5'd1;
            end else if (cnt < dw) begin
              rd_bit <= rd_shift[0]; cnt <= cnt + 1'b1;
            end else begin
              rd_en <= 1'b0; state <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dout_en = rd_en | status_mode;
  assign dout    = status_mode ? ~busy : rd_bit;
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int MEM_KBIT    = 1,
  parameter int PROG_CYCLES = 625000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org_sel,
  output logic dout,
  output logic dout_en
);
  localparam int AW16 = word16_addr_bits(MEM_KBIT);

  logic          cs_lvl, cs_rise, cs_fall, sk_rise, di_lvl, busy, prog_start, wen;
  logic [AW16:0] addr_q;
  logic [15:0]   data_q, rdata;
  prog_kind_e    prog_kind;

  mw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .cs_lvl(cs_lvl), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sk_rise(sk_rise), .di_lvl(di_lvl));

  mw_cmd_decoder #(.AW16(AW16)) u_dec (
    .clk(clk), .rst_n(rst_n), .org16(org_sel), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .sk_rise(sk_rise), .di(di_lvl), .busy(busy),
    .rdata(rdata), .addr_q(addr_q), .data_q(data_q), .prog_start(prog_start),
    .prog_kind(prog_kind), .wen(wen), .dout(dout), .dout_en(dout_en));

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy));

  mw_store #(.AW16(AW16)) u_store (
    .clk(clk), .rst_n(rst_n), .org16(org_sel), .we(prog_start),
    .kind(prog_kind), .addr(addr_q), .wdata(data_q), .rdata(rdata));

  // R1
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lvl |=> !dout_en);
  // R7
  start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(cs_fall));
  // R6
  start_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(wen));
  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy);
endmodule

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
  localparam int KBIT  = 1;
  localparam int PROG  = 600;
  localparam int AWB   = 6;            // 64 sixteen-bit words for 1 Kbit
  localparam int NBYTE = KBIT * 128;
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic dout, dout_en;

  mw_eeprom #(.MEM_KBIT(KBIT), .PROG_CYCLES(PROG)) u_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org_sel(org),
    .dout(dout), .dout_en(dout_en));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, skip_until = 0, busy_end = -100;
  string cur_req = "R12";

  // behavioural reference
  int mem_m [NBYTE];
  int st_m = 0, nh = 0, hdr = 0, nd = 0, dat = 0, ri = 0, word = 0, adr = 0, kind_m = 0;
  bit wen_m = 0, status_m = 0, exp_en = 0, exp_d = 0;

  function automatic int aw_m();  return org ? AWB : AWB + 1; endfunction
  function automatic int dw_m();  return org ? 16 : 8;        endfunction
  function automatic int word_of(int a);
    return org ? (mem_m[2*a] * 256 + mem_m[2*a+1]) : mem_m[a];
  endfunction

  task automatic model_rise(bit b);
    int sub;
    case (st_m)
      0: if (b && cyc >= busy_end) begin st_m = 1; nh = 0; hdr = 0; status_m = 0; end
      1: begin
        hdr = hdr * 2 + b; nh++;
        if (nh == 2 + aw_m()) begin
          adr = hdr % (1 << aw_m());
          sub = adr >> (aw_m() - 2);
          case (hdr >> aw_m())
            2: begin st_m = 3; exp_en = 1; exp_d = 0; ri = 0; end
            1: begin kind_m = 0; st_m = 2; nd = 0; dat = 0; end
            3: begin kind_m = 1; st_m = 4; end
            default: case (sub)
              3: begin wen_m = 1; st_m = 5; end
              0: begin wen_m = 0; st_m = 5; end
              2: begin kind_m = 3; st_m = 4; end
              default: begin kind_m = 2; st_m = 2; nd = 0; dat = 0; end
            endcase
          endcase
        end
      end
      2: begin dat = dat * 2 + b; nd++; if (nd == dw_m()) st_m = 4; end
      3: if (ri < dw_m()) begin
           if (ri == 0) word = word_of(adr);
           exp_d = (word >> (dw_m() - 1 - ri)) & 1; ri++;
         end else begin exp_en = 0; st_m = 5; end
      default: ;
    endcase
  endtask

  task automatic model_fall();
    if (st_m == 4 && wen_m) begin
      for (int i = 0; i < NBYTE; i++) begin
        if (kind_m == 3) mem_m[i] = 255;
        if (kind_m == 2) mem_m[i] = (org && i % 2 == 0) ? (dat >> 8) & 255 : dat & 255;
      end
      if (kind_m == 0 && org)  begin mem_m[2*adr] = (dat >> 8) & 255; mem_m[2*adr+1] = dat & 255; end
      if (kind_m == 0 && !org) mem_m[adr] = dat & 255;
      if (kind_m == 1 && org)  begin mem_m[2*adr] = 255; mem_m[2*adr+1] = 255; end
      if (kind_m == 1 && !org) mem_m[adr] = 255;
      busy_end = cyc + 4 + PROG;
    end
    st_m = 0; status_m = 0; exp_en = 0;
  endtask

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    bit e_en, e_d;
    cyc++;
    #2;
    if (cyc == LIMIT) begin
      fails++; checks++;
      $display("FAIL watchdog (R1..all) actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (rst_n && cyc >= skip_until && !(cyc >= busy_end - 2 && cyc <= busy_end + 2)) begin
      e_en = status_m ? 1'b1 : exp_en;
      e_d  = status_m ? (cyc >= busy_end) : exp_d;
      checks++;
      if (dout_en !== e_en || (e_en && dout !== e_d)) begin
        fails++;
        $display("FAIL %s cyc=%0d actual en=%0b d=%0b expected en=%0b d=%0b",
                 cur_req, cyc, dout_en, dout, e_en, e_d);
      end
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic set_cs(bit v);
    @(negedge clk);
    cs = v; skip_until = cyc + 6;
    if (v) begin if (cyc < busy_end) status_m = 1; end
    else model_fall();
    tick(8);
  endtask

  task automatic sk_bit(bit b);
    @(negedge clk); di = b; tick(8);
    sk = 1'b1; skip_until = cyc + 6;
    if (cs) model_rise(b);
    tick(8); sk = 1'b0;
  endtask

  task automatic send(int v, int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(bit'((v >> i) & 1));
  endtask

  task automatic cmd(int op, int a, bit has_data, int d);
    set_cs(1); sk_bit(1); send(op, 2); send(a, aw_m());
    if (has_data) send(d, dw_m());
    set_cs(0);
  endtask

  task automatic rd(int a, int lead);
    set_cs(1);
    for (int i = 0; i < lead; i++) sk_bit(0);
    sk_bit(1); send(2, 2); send(a, aw_m());
    for (int i = 0; i <= dw_m(); i++) sk_bit(0);
    set_cs(0);
  endtask

  task automatic wait_ready();
    while (cyc < busy_end + 6) tick(1);
  endtask

  function automatic int sub_adr(int s); return s << (aw_m() - 2); endfunction

  initial begin
    for (int i = 0; i < NBYTE; i++) mem_m[i] = 255;
    tick(5); rst_n = 1'b1; tick(3);
    cur_req = "R12"; checks++;
    if (dout_en !== 1'b0) begin
      fails++; $display("FAIL R12 actual en=%0b expected en=0", dout_en);
    end
    rd(3, 0);
    cur_req = "R6";  cmd(1, 3, 1, 16'h1111); rd(3, 0);
    cmd(0, sub_adr(3), 0, 0);
    cur_req = "R4";  cmd(1, 3, 1, 16'hA5C3);
    cur_req = "R9";  set_cs(1); wait_ready(); tick(20); set_cs(0);
    cur_req = "R4";  rd(3, 0);
    cur_req = "R2";  rd(3, 3);
    cur_req = "R1";  send(16'hB3F0, 16); rd(3, 0);
    cur_req = "R7";  set_cs(1); sk_bit(1); send(1, 2); send(5, aw_m()); send(8'h00, 8);
    set_cs(0); rd(5, 0);
    cur_req = "R8";  cmd(1, 10, 1, 16'h0F0F);
    set_cs(1); sk_bit(1); send(1, 2); send(12, aw_m()); send(0, 16);
    wait_ready(); set_cs(0); rd(12, 0); rd(10, 0);
    cur_req = "R5";  cmd(3, 3, 0, 0); wait_ready(); rd(3, 0);
    cur_req = "R10"; org = 1'b0; tick(4);
    cmd(1, 7, 1, 8'h3C); wait_ready(); rd(7, 0); rd(6, 0);
    org = 1'b1; tick(4); rd(3, 0);
    cur_req = "R11"; cmd(0, sub_adr(1), 1, 16'h1234); wait_ready(); rd(0, 0);
    cur_req = "R3";  rd(63, 0);
    cur_req = "R11"; cmd(0, sub_adr(2), 0, 0); wait_ready(); rd(10, 0);
    cur_req = "R6";  cmd(0, sub_adr(0), 0, 0); cmd(1, 4, 1, 16'h0000); rd(4, 0);
    tick(10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule